// File: doc/BRIEF.md
# Packed Lane Interleave and Saturating Narrow Unit

This block is a 64-bit packed-integer execution unit. It handles two kinds of operation. The first interleaves lanes of two operands at byte, 16-bit word or 32-bit doubleword size. The second narrows lanes with saturation. It keeps eight 64-bit registers. Each operation names a destination register, which supplies one operand and also receives the result. The second operand comes either from another register or from a single read on a simple memory port.

A register-sourced operation is taken and written on one clock edge. A memory-sourced operation starts a read on the memory port. The unit stays busy until the response arrives. It then writes on the response edge, unless the response reports an abort, in which case the destination is left as it was. Every result lane is built from the destination value as it stood before the write, and the result is stored with a single 64-bit write. A debug read port shows any register.

Top module: `simd_pack_unit`

## Requirements
- R1: After reset all eight registers read zero, and `busy`, `done` and `memReq` are low.
- R2: Low interleaves use the lower half of each operand. Destination elements fill the even lanes and source elements fill the odd lanes, with destination element 0 in lane 0. Codes: 0 = byte, 1 = word, 2 = doubleword. Code 2 leaves bits 31:0 unchanged and puts the source's bits 31:0 into bits 63:32.
- R3: High interleaves take element n/2 onward from each operand and alternate them, with destination first: lane 0 gets destination element n/2, lane 1 gets source element n/2. Codes: 3 = byte, 4 = word, 5 = doubleword.
- R4: Code 6 clamps each signed 16-bit lane to -128..127. Bytes 0-3 of the result come from destination words 0-3, and bytes 4-7 come from source words 0-3.
- R5: Code 7 reads each 16-bit lane as signed and clamps it to 0..255, so a negative word gives 0 and a word above 255 gives 255. It uses the same lane order as code 6.
- R6: Code 8 clamps each signed 32-bit lane to -32768..32767. Result words 0-1 come from destination doublewords 0-1, and words 2-3 come from source doublewords 0-1.
- R7: A request with `srcIsMem` low writes the destination on the edge that accepts it. `done` is high for the one cycle after that edge.
- R8: A request with `srcIsMem` high raises `busy` and `memReq` from the next cycle until the edge where `memRsp` is seen. The result is written on that edge and `done` follows one cycle later, so the fastest case takes two cycles. `memWide` is 0 (32-bit read, only `memData[31:0]` used) for code 2 and 1 for every other code.
- R9: A response with `memAbort` high leaves the destination unchanged, gives no `done` pulse, and drops `busy`.
- R10: A request raised while `busy` is high is ignored: nothing is written and nothing is queued.
- R11: Codes 9-15 leave the destination unchanged but still give a `done` pulse.
- R12: When the destination and the source register are the same, every lane is computed from the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Operation request |
| opCode | input | 4 | Operation code (0-8 defined) |
| dstIdx | input | 3 | Destination/result register index |
| srcIdx | input | 3 | Source register index (register source) |
| srcIsMem | input | 1 | Take source operand from memory port |
| busy | output | 1 | Memory read outstanding; requests ignored |
| done | output | 1 | Result was written on the previous edge |
| memReq | output | 1 | Memory read request, held until response |
| memWide | output | 1 | 1 = 64-bit read, 0 = 32-bit read |
| memRsp | input | 1 | Memory response valid |
| memAbort | input | 1 | Response reports an abort |
| memData | input | 64 | Memory response data |
| rdIdx | input | 3 | Debug read register index |
| rdData | output | 64 | Debug read data |

## Verification
The interleaves run on distinct, non-repeating byte patterns. These show whether any lane is misplaced, swapped between operands or taken from the wrong half. The packs sweep 256 sets of operands spread across the 16-bit range, together with seeded boundary words (±127/128, 255/256, 0, -1, ±32767/32768) and seeded boundary doublewords. These show whether the clamp limits, the signed versus unsigned reading, and the destination-then-source lane order are right. Each operation runs with a register source, with a memory source at several response latencies, and in place with destination equal to source; the in-place case exposes any lane that reads back partly written data. Aborted responses, requests made while busy, and the undefined codes are checked through the debug read port and `done`.

// File: rtl/pu_pkg.sv
package pu_pkg;
  localparam int REG_W    = 64;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int OP_W     = 4;

  localparam logic [OP_W-1:0] OP_UNPK_LO_B = 4'd0;
  localparam logic [OP_W-1:0] OP_UNPK_LO_W = 4'd1;
  localparam logic [OP_W-1:0] OP_UNPK_LO_D = 4'd2;
  localparam logic [OP_W-1:0] OP_UNPK_HI_B = 4'd3;
  localparam logic [OP_W-1:0] OP_UNPK_HI_W = 4'd4;
  localparam logic [OP_W-1:0] OP_UNPK_HI_D = 4'd5;
  localparam logic [OP_W-1:0] OP_PACK_SB   = 4'd6;
  localparam logic [OP_W-1:0] OP_PACK_UB   = 4'd7;
  localparam logic [OP_W-1:0] OP_PACK_SW   = 4'd8;

  typedef struct packed {
    logic             wrEn;
    logic             fromMem;
    logic [OP_W-1:0]  op;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
  } puStrobeT;

  function automatic logic [7:0] satSByte(input logic [15:0] v);
    if ($signed(v) > 16'sd127)       return 8'h7F;
    else if ($signed(v) < -16'sd128) return 8'h80;
    else                             return v[7:0];
  endfunction

  function automatic logic [7:0] satUByte(input logic [15:0] v);
    if (v[15])            return 8'h00;
    else if (v > 16'd255) return 8'hFF;
    else                  return v[7:0];
  endfunction

  function automatic logic [15:0] satSWord(input logic [31:0] v);
    if ($signed(v) > 32'sd32767)       return 16'h7FFF;
    else if ($signed(v) < -32'sd32768) return 16'h8000;
    else                               return v[15:0];
  endfunction
endpackage

// File: rtl/pu_ctrl.sv
module pu_ctrl
  import pu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [OP_W-1:0]  opCode,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic             srcIsMem,
  input  logic             memRsp,
  input  logic             memAbort,
  output puStrobeT         strb,
  output logic             busy,
  output logic             done,
  output logic             memReq,
  output logic             memWide
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctrlStateT;

  ctrlStateT        state;
  logic [OP_W-1:0]  heldOp;
  logic [IDX_W-1:0] heldDst;

  assign busy   = (state == ST_WAIT);
  assign memReq = busy;

  always_comb begin
    strb = '0;
    if (state == ST_IDLE) begin
      strb.op      = opCode;
      strb.dst     = dstIdx;
      strb.src     = srcIdx;
      strb.fromMem = 1'b0;
      strb.wrEn    = reqValid && !srcIsMem;
    end else begin
      strb.op      = heldOp;
      strb.dst     = heldDst;
      strb.src     = '0;
      strb.fromMem = 1'b1;
      strb.wrEn    = memRsp && !memAbort;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      heldOp  <= '0;
      heldDst <= '0;
      memWide <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= strb.wrEn;
      case (state)
        ST_IDLE: if (reqValid && srcIsMem) begin
          state   <= ST_WAIT;
          heldOp  <= opCode;
          heldDst <= dstIdx;
          memWide <= (opCode != OP_UNPK_LO_D);
        end
        ST_WAIT: if (memRsp) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && heldOp == OP_UNPK_LO_D) |-> !memWide)
    else $error("narrow read width wrong"); // R8
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memRsp) |-> !strb.wrEn)
    else $error("write while busy"); // R10
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memRsp && memAbort) |=> (!done && !busy))
    else $error("abort gave done or kept busy"); // R9
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> done)
    else $error("done missing after write"); // R7
endmodule

// File: rtl/pu_datapath.sv
module pu_datapath
  import pu_pkg::*;
#(
  parameter int N_REGS = NUM_REGS,
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  puStrobeT          strb,
  input  logic [DATA_W-1:0] memData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  localparam int BYTES  = DATA_W / 8;
  localparam int WORDS  = DATA_W / 16;
  localparam int DWORDS = DATA_W / 32;
  localparam int HALF   = DATA_W / 2;

  logic [N_REGS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0] dstV, srcV, result;
  logic [DATA_W-1:0] loB, hiB, loW, hiW, loD, hiD, packSB, packUB, packSW;

  assign dstV   = regs[strb.dst];
  assign srcV   = strb.fromMem ? memData : regs[strb.src];
  assign rdData = regs[rdIdx];

  for (genvar i = 0; i < BYTES / 2; i++) begin : gByteLane
    assign loB[16*i +: 8]   = dstV[8*i +: 8];
    assign loB[16*i+8 +: 8] = srcV[8*i +: 8];
    assign hiB[16*i +: 8]   = dstV[HALF+8*i +: 8];
    assign hiB[16*i+8 +: 8] = srcV[HALF+8*i +: 8];
  end

  for (genvar i = 0; i < WORDS / 2; i++) begin : gWordLane
    assign loW[32*i +: 16]    = dstV[16*i +: 16];
    assign loW[32*i+16 +: 16] = srcV[16*i +: 16];
    assign hiW[32*i +: 16]    = dstV[HALF+16*i +: 16];
    assign hiW[32*i+16 +: 16] = srcV[HALF+16*i +: 16];
  end

  for (genvar i = 0; i < DWORDS / 2; i++) begin : gDwordLane
    assign loD[64*i +: 32]    = dstV[32*i +: 32];
    assign loD[64*i+32 +: 32] = srcV[32*i +: 32];
    assign hiD[64*i +: 32]    = dstV[HALF+32*i +: 32];
    assign hiD[64*i+32 +: 32] = srcV[HALF+32*i +: 32];
  end

  for (genvar i = 0; i < WORDS; i++) begin : gNarrowByte
    assign packSB[8*i +: 8]      = satSByte(dstV[16*i +: 16]);
    assign packSB[HALF+8*i +: 8] = satSByte(srcV[16*i +: 16]);
    assign packUB[8*i +: 8]      = satUByte(dstV[16*i +: 16]);
    assign packUB[HALF+8*i +: 8] = satUByte(srcV[16*i +: 16]);
  end

  for (genvar i = 0; i < DWORDS; i++) begin : gNarrowWord
    assign packSW[16*i +: 16]      = satSWord(dstV[32*i +: 32]);
    assign packSW[HALF+16*i +: 16] = satSWord(srcV[32*i +: 32]);
  end

  always_comb begin
    case (strb.op)
      OP_UNPK_LO_B: result = loB;
      OP_UNPK_LO_W: result = loW;
      OP_UNPK_LO_D: result = loD;
      OP_UNPK_HI_B: result = hiB;
      OP_UNPK_HI_W: result = hiW;
      OP_UNPK_HI_D: result = hiD;
      OP_PACK_SB:   result = packSB;
      OP_PACK_UB:   result = packUB;
      OP_PACK_SW:   result = packSW;
      default:      result = dstV;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regs <= '0;
    else if (strb.wrEn) regs[strb.dst] <= result;
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(regs))
    else $error("register changed without write"); // R9
  AST_LOW_DWORD_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.op == OP_UNPK_LO_D) |=>
      (regs[$past(strb.dst)][HALF-1:0] == $past(dstV[HALF-1:0])))
    else $error("low doubleword disturbed"); // R2
endmodule

// File: rtl/simd_pack_unit.sv
module simd_pack_unit
  import pu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [3:0]       opCode,
  input  logic [2:0]       dstIdx,
  input  logic [2:0]       srcIdx,
  input  logic             srcIsMem,
  output logic             busy,
  output logic             done,
  output logic             memReq,
  output logic             memWide,
  input  logic             memRsp,
  input  logic             memAbort,
  input  logic [63:0]      memData,
  input  logic [2:0]       rdIdx,
  output logic [63:0]      rdData
);
  puStrobeT strb;

  pu_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opCode(opCode),
    .dstIdx(dstIdx), .srcIdx(srcIdx), .srcIsMem(srcIsMem),
    .memRsp(memRsp), .memAbort(memAbort), .strb(strb), .busy(busy),
    .done(done), .memReq(memReq), .memWide(memWide)
  );

  pu_datapath #(.N_REGS(NUM_REGS), .DATA_W(REG_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .memData(memData),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  AST_REQ_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && srcIsMem) |=> (busy && memReq))
    else $error("memory request not raised"); // R8
endmodule

// File: tb/test_simd_pack_unit.sv
module test_simd_pack_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, srcIsMem = 1'b0, memRsp = 1'b0, memAbort = 1'b0;
  logic [3:0] opCode = '0;
  logic [2:0] dstIdx = '0, srcIdx = '0, rdIdx = '0;
  logic [63:0] memData = '0;
  logic busy, done, memReq, memWide;
  logic [63:0] rdData;
  int nTests = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  simd_pack_unit i_simd_pack_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opCode(opCode),
    .dstIdx(dstIdx), .srcIdx(srcIdx), .srcIsMem(srcIsMem), .busy(busy),
    .done(done), .memReq(memReq), .memWide(memWide), .memRsp(memRsp),
    .memAbort(memAbort), .memData(memData), .rdIdx(rdIdx), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input int idx, output logic [63:0] v);
    rdIdx = 3'(idx);
    #1 v = rdData;
  endtask

  function automatic logic [63:0] clampTo(input longint v, input longint lo, input longint hi);
    longint c;
    c = (v < lo) ? lo : ((v > hi) ? hi : v);
    return 64'(c);
  endfunction

  function automatic logic [63:0] modelOut(input int op, input logic [63:0] d, input logic [63:0] s);
    logic [63:0] r, t;
    r = d;
    case (op)
      0: for (int i = 0; i < 4; i++) begin r[16*i +: 8] = d[8*i +: 8]; r[16*i+8 +: 8] = s[8*i +: 8]; end
      1: for (int i = 0; i < 2; i++) begin r[32*i +: 16] = d[16*i +: 16]; r[32*i+16 +: 16] = s[16*i +: 16]; end
      2: r = {s[31:0], d[31:0]};
      3: for (int i = 0; i < 4; i++) begin r[16*i +: 8] = d[32+8*i +: 8]; r[16*i+8 +: 8] = s[32+8*i +: 8]; end
      4: for (int i = 0; i < 2; i++) begin r[32*i +: 16] = d[32+16*i +: 16]; r[32*i+16 +: 16] = s[32+16*i +: 16]; end
      5: r = {s[63:32], d[63:32]};
      6, 7: for (int i = 0; i < 4; i++) begin
        t = clampTo(longint'($signed(d[16*i +: 16])), (op == 6) ? -128 : 0, (op == 6) ? 127 : 255);
        r[8*i +: 8] = t[7:0];
        t = clampTo(longint'($signed(s[16*i +: 16])), (op == 6) ? -128 : 0, (op == 6) ? 127 : 255);
        r[32+8*i +: 8] = t[7:0];
      end
      8: for (int i = 0; i < 2; i++) begin
        t = clampTo(longint'($signed(d[32*i +: 32])), -32768, 32767);
        r[16*i +: 16] = t[15:0];
        t = clampTo(longint'($signed(s[32*i +: 32])), -32768, 32767);
        r[32+16*i +: 16] = t[15:0];
      end
      default: r = d;
    endcase
    return r;
  endfunction

  task automatic memOp(input int op, input int dst, input logic [63:0] data, input bit abort, input int lat);
    @(negedge clk);
    reqValid = 1; opCode = 4'(op); dstIdx = 3'(dst); srcIdx = 0; srcIsMem = 1;
    @(negedge clk);
    reqValid = 0; srcIsMem = 0;
    chk("R8 busy raised", {63'b0, busy}, 64'd1);
    chk("R8 memReq raised", {63'b0, memReq}, 64'd1);
    chk("R8 memWide", {63'b0, memWide}, (op == 2) ? 64'd0 : 64'd1);
    repeat (lat) @(negedge clk);
    memRsp = 1; memData = data; memAbort = abort;
    @(negedge clk);
    memRsp = 0; memAbort = 0;
    chk(abort ? "R9 no done on abort" : "R8 done after response", {63'b0, done}, abort ? 64'd0 : 64'd1);
    chk("R8 busy cleared", {63'b0, busy}, 64'd0);
  endtask

  task automatic regOp(input int op, input int dst, input int src);
    @(negedge clk);
    reqValid = 1; opCode = 4'(op); dstIdx = 3'(dst); srcIdx = 3'(src); srcIsMem = 0;
    @(negedge clk);
    reqValid = 0;
    chk("R7 done after register op", {63'b0, done}, 64'd1);
  endtask

  task automatic loadReg(input int idx, input logic [63:0] v);
    memOp(2, idx, {32'hDEAD_BEEF, v[31:0]}, 0, 0);
    memOp(5, idx, {v[63:32], 32'h0BAD_F00D}, 0, 0);
  endtask

  function automatic logic [63:0] patA(input int k);
    logic [63:0] p;
    for (int b = 0; b < 8; b++) p[8*b +: 8] = 8'(k * 8 + b + 1);
    return p;
  endfunction
  function automatic logic [63:0] patB(input int k);
    logic [63:0] p;
    for (int b = 0; b < 8; b++) p[8*b +: 8] = 8'(8'h80 + k * 8 + b + 3);
    return p;
  endfunction

  function automatic logic [15:0] edgeWord(input int n);
    case (n % 16)
      0: return 16'h0000;  1: return 16'hFFFF;  2: return 16'h007F;  3: return 16'h0080;
      4: return 16'hFF80;  5: return 16'hFF7F;  6: return 16'h00FF;  7: return 16'h0100;
      8: return 16'h7FFF;  9: return 16'h8000; 10: return 16'h0001; 11: return 16'hFFFE;
      12: return 16'h00FE; 13: return 16'h0081; 14: return 16'hFF81; default: return 16'h7F00;
    endcase
  endfunction
  function automatic logic [31:0] edgeDword(input int n);
    case (n % 8)
      0: return 32'h0000_7FFF; 1: return 32'h0000_8000; 2: return 32'hFFFF_8000; 3: return 32'hFFFF_7FFF;
      4: return 32'h7FFF_FFFF; 5: return 32'h8000_0000; 6: return 32'h0000_0000; default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic genPair(input int k, output logic [63:0] d, output logic [63:0] s);
    logic [127:0] w;
    for (int j = 0; j < 8; j++)
      w[16*j +: 16] = (k < 16) ? edgeWord(k + j) : 16'(k * 257 + j * 16'h1111);
    if (k >= 16 && k < 24)
      for (int j = 0; j < 4; j++) w[32*j +: 32] = edgeDword(k + j);
    d = w[63:0];
    s = w[127:64];
  endtask

  task automatic runCase(input int op, input logic [63:0] a, input logic [63:0] b, input int k, input string tag);
    logic [63:0] v;
    loadReg(1, a); loadReg(2, b);
    regOp(op, 1, 2);
    readReg(1, v); chk({tag, " register source"}, v, modelOut(op, a, b));
    readReg(2, v); chk({tag, " source untouched"}, v, b);
    loadReg(1, a);
    memOp(op, 1, b, 0, k % 3);
    readReg(1, v); chk({tag, " memory source"}, v, modelOut(op, a, b));
  endtask

  initial begin
    logic [63:0] v, a, b;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {63'b0, busy}, 0);
    chk("R1 done", {63'b0, done}, 0);
    chk("R1 memReq", {63'b0, memReq}, 0);
    rstN = 1;
    for (int i = 0; i < 8; i++) begin readReg(i, v); chk("R1 register zero", v, 0); end

    // R2 low and R3 high interleaves
    for (int k = 0; k < 24; k++)
      for (int op = 0; op < 6; op++)
        runCase(op, patA(k), patB(k), k, (op < 3) ? "R2 low interleave" : "R3 high interleave");

    // R4 R5 R6 saturating packs
    for (int k = 0; k < 256; k++) begin
      genPair(k, a, b);
      runCase(6, a, b, k, "R4 signed byte pack");
      runCase(7, a, b, k, "R5 unsigned byte pack");
      runCase(8, a, b, k, "R6 signed word pack");
    end

    // R12 in-place destination equals source
    for (int op = 0; op < 9; op++) begin
      genPair(op + 3, a, b);
      a = a ^ patA(op);
      loadReg(3, a);
      regOp(op, 3, 3);
      readReg(3, v); chk("R12 in-place", v, modelOut(op, a, a));
    end

    // R7 done lasts one cycle
    @(negedge clk);
    chk("R7 done single pulse", {63'b0, done}, 0);

    // R8 latency sweep on narrow read
    for (int lat = 0; lat < 5; lat++) begin
      loadReg(4, patA(lat));
      memOp(2, 4, patB(lat), 0, lat);
      readReg(4, v); chk("R8 latency narrow read", v, modelOut(2, patA(lat), patB(lat)));
    end

    // R9 abort leaves register unchanged
    for (int op = 0; op < 9; op++) begin
      loadReg(5, patA(op + 40));
      memOp(op, 5, patB(op), 1, op % 3);
      readReg(5, v); chk("R9 abort keeps register", v, patA(op + 40));
    end

    // R10 request while busy is ignored
    loadReg(6, patA(50)); loadReg(7, patB(50)); loadReg(4, patA(51));
    @(negedge clk);
    reqValid = 1; opCode = 0; dstIdx = 4; srcIsMem = 1;
    @(negedge clk);
    opCode = 3; dstIdx = 6; srcIdx = 7; srcIsMem = 0;
    @(negedge clk);
    reqValid = 0;
    chk("R10 no done while busy", {63'b0, done}, 0);
    readReg(6, v); chk("R10 busy request ignored", v, patA(50));
    memRsp = 1; memData = patB(51);
    @(negedge clk);
    memRsp = 0;
    chk("R10 pending op completes", {63'b0, done}, 1);
    readReg(4, v); chk("R10 pending result", v, modelOut(0, patA(51), patB(51)));
    @(negedge clk);
    chk("R10 nothing queued", {63'b0, done}, 0);
    readReg(6, v); chk("R10 register after busy", v, patA(50));

    // R11 undefined codes
    for (int op = 9; op < 16; op++) begin
      regOp(op, 6, 7);
      readReg(6, v); chk("R11 undefined code no change", v, patA(50));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule